// File: doc/BRIEF.md
# Dual-Mode Counter/Timer

This block is a down-counter with a preload register. It can run as an event counter or as a periodic timer. A three-bit mode code chooses both the behaviour and where the count ticks come from. The sources are a primary external tick input, an auxiliary external tick input, the main clock, and either the main clock or the primary input divided by sixteen. A start strobe loads the preload value and starts counting. A stop strobe clears the ready flag. In counter mode the stop strobe also freezes the count.

In counter mode, every time the count passes zero it wraps to all ones, keeps running and raises the ready flag. In timer mode, each time the count passes zero it reloads from the preload value and toggles a square-wave output. The ready flag rises only on every second such reload. Interrupt logic is meant to watch the ready flag. The square wave can drive a pin directly.

Top module: `ctmr_top`

## Requirements
- R1: After synchronous reset, count_o is 0, ready_o is 0 and wave_o is 0, and the block ignores ticks until the first start.
- R2: A start strobe loads preload_i into count_o on the next clock, starts the counter, clears wave_o, restarts the every-second-underflow phase and clears the divide-by-16 prescaler.
- R3: While the block is running, each selected tick lowers count_o by one, as long as count_o is not zero.
- R4: In counter mode (mode_i bit 2 = 0), a tick at count 0 sets count_o to all ones and sets ready_o, and counting continues.
- R5: In timer mode (mode_i bit 2 = 1), a tick at count 0 reloads count_o from preload_i and inverts wave_o.
- R6: In timer mode, ready_o is set on the second, fourth, sixth and later even-numbered underflows after start, and is not set on the odd-numbered ones.
- R7: In counter mode, a stop strobe clears ready_o and freezes count_o until the next start.
- R8: In timer mode, a stop strobe clears ready_o, and count_o keeps decrementing.
- R9: The mode codes select these tick sources:
  - 0 and 4: primary external input.
  - 1 and 2: auxiliary external input.
  - 3 and 7: the main clock divided by 16.
  - 5: the primary external input divided by 16.
  - 6: the main clock, one tick per cycle.
- R10: Each external input passes through a two-stage synchronizer and an edge detector. Each rising edge is one tick, and count_o changes on the third clock edge after the input rises.
- R11: A divided source gives one tick per 16 base ticks. The first tick after start comes on the 16th base tick.
- R12: A start strobe takes priority over a stop strobe or a tick in the same cycle. ready_o is not touched by start and stays set until a stop or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| preload_i | input | 16 | Preload value |
| mode_i | input | 3 | Mode and tick-source code |
| start_i | input | 1 | Start strobe, one cycle |
| stop_i | input | 1 | Stop strobe, one cycle |
| ext_tick_i | input | 1 | Primary external tick input (asynchronous) |
| aux_tick_i | input | 1 | Auxiliary external tick input (asynchronous) |
| count_o | output | 16 | Current count |
| ready_o | output | 1 | Ready flag for the interrupt logic |
| wave_o | output | 1 | Square-wave output of timer mode |

## Verification
A wrong count value shows on count_o at the next clock edge. A lost or extra underflow shows within one reload period, either as a wrong wave_o level or as a ready_o that rises one underflow too early or too late. A prescaler or synchronizer that is off by even one stage moves the first decrement by at least one cycle, so comparing every clock against a behavioural model exposes it at once. Stop and start priority is checked in the cycle right after the strobe, in both modes.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_AUX = 2'd1,
    SRC_CLK = 2'd2
  } src_e;

  typedef struct packed {
    src_e src;
    logic div16;
    logic timer;
  } msel_t;

  function automatic msel_t decode_mode(input logic [2:0] m);
    msel_t r;
    r.timer = m[2];
    unique case (m)
      3'd0, 3'd4: begin r.src = SRC_EXT; r.div16 = 1'b0; end
      3'd1, 3'd2: begin r.src = SRC_AUX; r.div16 = 1'b0; end
      3'd3, 3'd7: begin r.src = SRC_CLK; r.div16 = 1'b1; end
      3'd5:       begin r.src = SRC_EXT; r.div16 = 1'b1; end
      default:    begin r.src = SRC_CLK; r.div16 = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ctmr_edge_sync.sv
module ctmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R10: an edge pulse lasts a single cycle
  p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ctmr_tick_sel.sv
module ctmr_tick_sel
  import ctmr_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       start,
  input  logic       ext_in,
  input  logic       aux_in,
  output logic       tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic  ext_rise, aux_rise, base;
  logic  [PRE_W-1:0] pre_q;
  msel_t sel;

  ctmr_edge_sync #(.STAGES(STAGES)) u_ext (
    .clk(clk), .rst(rst), .din(ext_in), .rise(ext_rise));
  ctmr_edge_sync #(.STAGES(STAGES)) u_aux (
    .clk(clk), .rst(rst), .din(aux_in), .rise(aux_rise));

  always_comb begin
    sel = decode_mode(mode);
    unique case (sel.src)
      SRC_EXT: base = ext_rise;
      SRC_AUX: base = aux_rise;
      default: base = 1'b1;
    endcase
    tick = sel.div16 ? (base && pre_q == PRE_LAST) : base;
  end

  always_ff @(posedge clk) begin
    if (rst || start)           pre_q <= '0;
    else if (sel.div16 && base) pre_q <= pre_q + 1'b1;
  end

  // R2 / R11: start restarts the prescaler
  p_pre_clear_r11: assert property (@(posedge clk) disable iff (rst)
    start |=> pre_q == '0);
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          timer,
  input  logic          start,
  input  logic          stop,
  input  logic          tick,
  input  logic [CW-1:0] preload,
  output logic [CW-1:0] count_q,
  output logic          ready_q,
  output logic          wave_q
);
  logic running_q, phase_q, hold;

  assign hold = stop && !timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      ready_q   <= 1'b0;
      wave_q    <= 1'b0;
      running_q <= 1'b0;
      phase_q   <= 1'b0;
    end else if (start) begin
      count_q   <= preload;
      running_q <= 1'b1;
      wave_q    <= 1'b0;
      phase_q   <= 1'b0;
    end else begin
      if (stop) begin
        ready_q <= 1'b0;
        if (!timer) running_q <= 1'b0;
      end
      if (running_q && tick && !hold) begin
        if (count_q == '0) begin
          if (timer) begin
            count_q <= preload;
            wave_q  <= ~wave_q;
            phase_q <= ~phase_q;
            if (phase_q && !stop) ready_q <= 1'b1;
          end else begin
            count_q <= '1;
            ready_q <= 1'b1;
          end
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> count_q == $past(preload) && !wave_q);
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (running_q && tick && count_q == '0 && !timer && !start && !stop)
      |=> count_q == '1 && ready_q);
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (running_q && tick && count_q == '0 && timer && !start)
      |=> count_q == $past(preload) && wave_q != $past(wave_q));
  p_stop_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !ready_q);
  p_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (stop && !start && !timer) |=> $stable(count_q));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] preload_i,
  input  logic [2:0]       mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_tick_i,
  input  logic             aux_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o,
  output logic             wave_o
);
  logic  tick;
  msel_t sel;

  assign sel = decode_mode(mode_i);

  ctmr_tick_sel #(.PRE_W(PRE_W), .STAGES(STAGES)) u_sel (
    .clk(clk), .rst(rst), .mode(mode_i), .start(start_i),
    .ext_in(ext_tick_i), .aux_in(aux_tick_i), .tick(tick));

  ctmr_core #(.CW(CNT_W)) u_core (
    .clk(clk), .rst(rst), .timer(sel.timer), .start(start_i),
    .stop(stop_i), .tick(tick), .preload(preload_i),
    .count_q(count_o), .ready_q(ready_o), .wave_q(wave_o));

  // R1: outputs come out of reset cleared
  p_reset_r1: assert property (@(posedge clk)
    rst |=> count_o == '0 && !ready_o && !wave_o);
endmodule

// File: tb/ctmr_top_tb_top.sv
`timescale 1ns/1ps
module ctmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] preload = '0;
  logic [2:0]  mode = '0;
  logic        start = 0, stop = 0, ext = 0, aux = 0;
  logic [15:0] count;
  logic        ready, wave;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  ctmr_top dut_i (
    .clk(clk), .rst(rst), .preload_i(preload), .mode_i(mode),
    .start_i(start), .stop_i(stop), .ext_tick_i(ext), .aux_tick_i(aux),
    .count_o(count), .ready_o(ready), .wave_o(wave));

  // behavioural reference model
  int m_cnt, m_pc, m_ready, m_wave, m_run, m_uf;
  int e1, e2, e3, a1, a2, a3;
  always @(posedge clk) begin
    int erise, arise, base, div, tk;
    if (rst) begin
      m_cnt = 0; m_pc = 0; m_ready = 0; m_wave = 0; m_run = 0; m_uf = 0;
      e1 = 0; e2 = 0; e3 = 0; a1 = 0; a2 = 0; a3 = 0;
    end else begin
      erise = e2 && !e3; arise = a2 && !a3;
      e3 = e2; e2 = e1; e1 = ext;
      a3 = a2; a2 = a1; a1 = aux;
      case (mode)
        0, 4: begin base = erise; div = 0; end
        1, 2: begin base = arise; div = 0; end
        5:    begin base = erise; div = 1; end
        6:    begin base = 1;     div = 0; end
        default: begin base = 1;  div = 1; end
      endcase
      tk = div ? (base && m_pc == 15) : base;
      if (start) m_pc = 0;
      else if (div && base) m_pc = (m_pc + 1) % 16;
      if (start) begin
        m_cnt = preload; m_run = 1; m_wave = 0; m_uf = 0;
      end else begin
        if (stop) begin m_ready = 0; if (mode < 4) m_run = 0; end
        if (m_run && tk && !(stop && mode < 4)) begin
          if (m_cnt == 0) begin
            if (mode >= 4) begin
              m_cnt = preload; m_wave = 1 - m_wave; m_uf++;
              if (m_uf % 2 == 0 && !stop) m_ready = 1;
            end else begin
              m_cnt = 65535; m_ready = 1;
            end
          end else m_cnt--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (count !== m_cnt[15:0] || ready !== m_ready[0] || wave !== m_wave[0]) begin
        fails++;
        $display("FAIL %s model: count=%h/%h ready=%b/%b wave=%b/%b (actual/expected)",
                 tag, count, m_cnt[15:0], ready, m_ready[0], wave, m_wave[0]);
      end
    end
  end

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic [2:0] m, input logic [15:0] p);
    mode = m; preload = p; start = 1; cyc(1); start = 0;
  endtask

  task automatic do_stop();
    stop = 1; cyc(1); stop = 0;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin ext = 1; cyc(2); ext = 0; cyc(2); end
  endtask

  task automatic pulse_aux(input int n);
    for (int i = 0; i < n; i++) begin aux = 1; cyc(2); aux = 0; cyc(2); end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected done");
    finish_up();
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    tag = "R1";
    chk("R1 count", count, 16'h0); chk("R1 ready", {15'b0, ready}, 16'h0);
    chk("R1 wave", {15'b0, wave}, 16'h0);
    cmp_en = 1;
    mode = 6; cyc(5);
    chk("R1 idle", count, 16'h0);

    // timer from main clock
    tag = "R2"; do_start(3'd6, 16'd5);
    chk("R2 load", count, 16'd5);
    tag = "R5"; cyc(6);
    chk("R5 reload", count, 16'd5); chk("R5 wave", {15'b0, wave}, 16'h1);
    chk("R6 first uf no ready", {15'b0, ready}, 16'h0);
    tag = "R6"; cyc(6);
    chk("R6 second uf ready", {15'b0, ready}, 16'h1);
    chk("R6 wave back", {15'b0, wave}, 16'h0);
    tag = "R8"; do_stop();
    chk("R8 ready cleared", {15'b0, ready}, 16'h0);
    cyc(1); chk("R8 still running", count, 16'd3);
    cyc(20);

    // counter, main clock / 16
    tag = "R11"; do_start(3'd3, 16'd1);
    cyc(15); chk("R11 before 16th", count, 16'd1);
    cyc(1);  chk("R11 16th tick", count, 16'd0);
    tag = "R4"; cyc(16);
    chk("R4 wrap", count, 16'hFFFF); chk("R4 ready", {15'b0, ready}, 16'h1);
    cyc(16); chk("R4 keeps running", count, 16'hFFFE);
    tag = "R7"; do_stop();
    chk("R7 ready cleared", {15'b0, ready}, 16'h0);
    cyc(40); chk("R7 frozen", count, 16'hFFFE);

    // external edge latency and counting
    tag = "R10"; do_start(3'd0, 16'd3);
    ext = 1; cyc(2); chk("R10 not yet", count, 16'd3);
    cyc(1); chk("R10 third edge", count, 16'd2);
    cyc(3); chk("R10 high held", count, 16'd2);
    ext = 0; cyc(2);
    tag = "R3"; pulse_ext(2); cyc(3); chk("R3 decrement", count, 16'd0);
    tag = "R4"; pulse_ext(1); cyc(3);
    chk("R4 ext wrap", count, 16'hFFFF);
    do_stop();

    // auxiliary source, codes 1 and 2
    tag = "R9"; do_start(3'd1, 16'd10);
    pulse_ext(3); pulse_aux(4); cyc(3); chk("R9 aux code1", count, 16'd6);
    mode = 2; pulse_aux(2); cyc(3); chk("R9 aux code2", count, 16'd4);
    do_stop();

    // primary input / 16 in timer mode
    tag = "R9"; do_start(3'd5, 16'd2);
    pulse_ext(15); cyc(3); chk("R9 div ext 15", count, 16'd2);
    pulse_ext(1); cyc(3);  chk("R9 div ext 16", count, 16'd1);
    pulse_ext(40); cyc(3);

    // timer on main clock / 16
    tag = "R9"; do_start(3'd7, 16'd0);
    cyc(100);
    // code 4: timer on primary input
    tag = "R9"; do_start(3'd4, 16'd1); pulse_ext(9); cyc(3);

    // priority
    tag = "R12"; mode = 6; preload = 16'd9; start = 1; stop = 1; cyc(1);
    start = 0; stop = 0;
    chk("R12 start wins", count, 16'd9);
    cyc(1); chk("R12 running", count, 16'd8);
    cyc(40);
    tag = "R12"; do_start(3'd0, 16'd0); pulse_ext(1); cyc(3);
    chk("R12 ready set", {15'b0, ready}, 16'h1);
    do_start(3'd0, 16'd4);
    chk("R12 start keeps ready", {15'b0, ready}, 16'h1);
    cyc(2);
    finish_up();
  end
endmodule